// File: doc/BRIEF.md
# Host Port for a Tile Video Controller

This block sits between an 8-bit processor bus and the video memory of a tile-based display controller. The processor sees two ports. A control port takes byte pairs that either load an internal register or point the memory address counter at a location for reading or for writing. A data port moves single bytes to or from video memory through that counter.

The processor never reaches video memory directly. A data-port write is parked in a one-byte buffer and committed when the memory side offers an access slot. A data-port read returns the contents of a read-ahead latch, and then schedules the next fetch. The latch is filled only in a granted slot. A program that reads the data port too soon after setting up a read address therefore gets the old latch contents. The slot source, which is the display timing logic, pulses a grant input once per slot. This block raises a request whenever it has work and, when it has both kinds of work, serves the pending write first.

The two-byte sequencer is a two-state machine: `SEQ_FIRST` waits for a first control byte and latches it, then `SEQ_SECOND` decodes the pair on the next control write. The transition from `SEQ_SECOND` back to `SEQ_FIRST` is taken on that second write, on any data-port access, or on a control-port read. These last two cases also apply in `SEQ_FIRST`, which stays put. The access arbiter has four states: `ARB_IDLE`, `ARB_WRITE` (write pending), `ARB_FETCH` (prefetch pending) and `ARB_WRITE_FETCH` (both). Setting a write moves it into a state with the write part. Setting a fetch moves it into a state with the fetch part. A write-mode address setup drops the fetch part. A grant drops the write part if it is present, otherwise the fetch part.

Top module: `vdp_host_port`

## Requirements
- R1: After reset, `mem_req` and `reg_we` are low and a data-port read returns 0x00.
- R2: A single control write has no visible effect. When a second control byte has bit 7 set, `reg_we` is high for exactly one cycle, in the cycle after that write. In that cycle `reg_num` is the second byte's low `REG_W` bits and `reg_data` is the first byte. No grant is needed for this.
- R3: When the second control byte has bits 7 and 6 clear, the address counter loads {second byte low `ADDR_W-8` bits, first byte}. A prefetch request then appears in the next cycle, with `mem_req`=1, `mem_we`=0 and `mem_addr` equal to the loaded address.
- R4: When the second control byte has bit 7 clear and bit 6 set, the address loads the same way, no prefetch is requested, and any pending prefetch is dropped.
- R5: A data-port write sets `mem_req`=1 and `mem_we`=1, with `mem_wdata` equal to the byte and `mem_addr` equal to the counter. The request holds until a grant, and the counter then advances by one.
- R6: The read-ahead latch changes only in a granted read slot. A data read before that grant returns the previous latch byte.
- R7: After a granted fetch from address A, a data read returns the byte at A. The read then requests a new fetch at A+1.
- R8: When a write and a prefetch are both pending, the first grant commits the write and the next grant performs the fetch at the following address.
- R9: Any data-port access or control-port read returns the sequencer to first-byte state. A control-port read returns 0x00.
- R10: The address counter wraps from its all-ones value to zero.
- R11: A grant pulse while `mem_req` is low changes neither the address nor the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_cs | input | 1 | One-cycle host access strobe |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_sel | input | 1 | 1 = control port, 0 = data port |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Read-ahead latch on data port, 0x00 on control port |
| reg_we | output | 1 | Register write strobe |
| reg_num | output | REG_W | Register number |
| reg_data | output | 8 | Register value |
| mem_req | output | 1 | Access wanted in the next slot |
| mem_we | output | 1 | 1 = pending access is a write |
| mem_addr | output | ADDR_W | Video memory address |
| mem_wdata | output | 8 | Write buffer contents |
| mem_grant | input | 1 | One pulse per access slot |
| mem_rdata | input | 8 | Memory byte at `mem_addr`, valid with the grant |

## Verification
The bench builds the block with its defaults: a 14-bit address (`ADDR_W`=14) and a 6-bit register number (`REG_W`=6). With these values, an address setup reaches the top of memory, so the wrap from 0x3FFF to 0x0000 can be reached in one write. The bench supplies memory data from a computed address pattern, so every fetched byte can be predicted. It places grants by hand, which lets it issue a data read before the fetch and so expose the stale-latch case, and lets it hold a write and a prefetch pending together.

// File: rtl/vhp_pkg.sv
package vhp_pkg;
    typedef enum logic {
        SEQ_FIRST,
        SEQ_SECOND
    } seq_state_t;

    typedef enum logic [1:0] {
        ARB_IDLE,
        ARB_WRITE,
        ARB_FETCH,
        ARB_WRITE_FETCH
    } arb_state_t;

    localparam int unsigned CTRL_REG_BIT  = 7;
    localparam int unsigned CTRL_MODE_BIT = 6;
endpackage

// File: rtl/vhp_ctrl_seq.sv
module vhp_ctrl_seq
    import vhp_pkg::*;
#(
    parameter int unsigned ADDR_W = 14,
    parameter int unsigned REG_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_cs,
    input  logic              host_wr,
    input  logic              host_sel,
    input  logic [7:0]        host_wdata,
    output logic              cmd_reg_wr,
    output logic [REG_W-1:0]  cmd_reg_num,
    output logic [7:0]        cmd_reg_data,
    output logic              cmd_addr_ld,
    output logic              cmd_rd_mode,
    output logic [ADDR_W-1:0] cmd_addr
);
    localparam int unsigned HI_W = ADDR_W - 8;

    seq_state_t state_q, state_d;
    logic [7:0] first_q;
    logic       ctrl_wr, other_acc;

    assign ctrl_wr   = host_cs && host_sel && host_wr;
    assign other_acc = host_cs && !(host_sel && host_wr);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_FIRST: begin
                if (ctrl_wr) state_d = SEQ_SECOND;
            end
            SEQ_SECOND: begin
                if (ctrl_wr || other_acc) state_d = SEQ_FIRST;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_FIRST;
            first_q <= 8'h00;
        end else begin
            state_q <= state_d;
            if (ctrl_wr && state_q == SEQ_FIRST) first_q <= host_wdata;
        end
    end

    always_comb begin
        cmd_reg_wr   = 1'b0;
        cmd_addr_ld  = 1'b0;
        cmd_rd_mode  = !host_wdata[CTRL_MODE_BIT];
        cmd_reg_num  = host_wdata[REG_W-1:0];
        cmd_reg_data = first_q;
        cmd_addr     = {host_wdata[HI_W-1:0], first_q};
        unique case (state_q)
            SEQ_FIRST: ;
            SEQ_SECOND: begin
                if (ctrl_wr) begin
                    cmd_reg_wr  = host_wdata[CTRL_REG_BIT];
                    cmd_addr_ld = !host_wdata[CTRL_REG_BIT];
                end
            end
        endcase
    end

    // R9
    first_flag_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        other_acc |=> state_q == SEQ_FIRST);
endmodule

// File: rtl/vhp_addr_cnt.sv
module vhp_addr_cnt #(
    parameter int unsigned ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld,
    input  logic [ADDR_W-1:0] ld_val,
    input  logic              inc,
    output logic [ADDR_W-1:0] addr
);
    always_ff @(posedge clk) begin
        if (!rst_n)   addr <= '0;
        else if (ld)  addr <= ld_val;
        else if (inc) addr <= addr + 1'b1;
    end

    // R10
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !ld) |=> addr == ADDR_W'($past(addr) + 1'b1));
endmodule

// File: rtl/vhp_access_arb.sv
module vhp_access_arb
    import vhp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_wr,
    input  logic set_rd,
    input  logic clr_rd,
    input  logic grant,
    output logic req,
    output logic we,
    output logic served_wr,
    output logic served_rd
);
    arb_state_t state_q, state_d;
    logic wr_p, rd_p, wr_n, rd_n;

    always_comb begin
        wr_p = 1'b0;
        rd_p = 1'b0;
        unique case (state_q)
            ARB_IDLE:        ;
            ARB_WRITE:       wr_p = 1'b1;
            ARB_FETCH:       rd_p = 1'b1;
            ARB_WRITE_FETCH: begin wr_p = 1'b1; rd_p = 1'b1; end
        endcase
    end

    always_comb begin
        served_wr = grant && wr_p;
        served_rd = grant && !wr_p && rd_p;
        wr_n = (wr_p && !served_wr) || set_wr;
        rd_n = ((rd_p && !served_rd) || set_rd) && !clr_rd;
        unique case ({wr_n, rd_n})
            2'b00: state_d = ARB_IDLE;
            2'b10: state_d = ARB_WRITE;
            2'b01: state_d = ARB_FETCH;
            2'b11: state_d = ARB_WRITE_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ARB_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        req = 1'b0;
        we  = 1'b0;
        unique case (state_q)
            ARB_IDLE:        ;
            ARB_WRITE:       begin req = 1'b1; we = 1'b1; end
            ARB_FETCH:       req = 1'b1;
            ARB_WRITE_FETCH: begin req = 1'b1; we = 1'b1; end
        endcase
    end

    // R5
    write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && we && !grant) |=> (req && we));
endmodule

// File: rtl/vdp_host_port.sv
module vdp_host_port
    import vhp_pkg::*;
#(
    parameter int unsigned ADDR_W = 14,
    parameter int unsigned REG_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_cs,
    input  logic              host_wr,
    input  logic              host_sel,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    output logic              reg_we,
    output logic [REG_W-1:0]  reg_num,
    output logic [7:0]        reg_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic              mem_grant,
    input  logic [7:0]        mem_rdata
);
    logic              cmd_reg_wr, cmd_addr_ld, cmd_rd_mode;
    logic [REG_W-1:0]  cmd_reg_num;
    logic [7:0]        cmd_reg_data;
    logic [ADDR_W-1:0] cmd_addr;
    logic              data_wr, data_rd;
    logic              served_wr, served_rd;
    logic [7:0]        wbuf_q, rd_latch_q;

    assign data_wr = host_cs && !host_sel && host_wr;
    assign data_rd = host_cs && !host_sel && !host_wr;

    vhp_ctrl_seq #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_cs      (host_cs),
        .host_wr      (host_wr),
        .host_sel     (host_sel),
        .host_wdata   (host_wdata),
        .cmd_reg_wr   (cmd_reg_wr),
        .cmd_reg_num  (cmd_reg_num),
        .cmd_reg_data (cmd_reg_data),
        .cmd_addr_ld  (cmd_addr_ld),
        .cmd_rd_mode  (cmd_rd_mode),
        .cmd_addr     (cmd_addr)
    );

    vhp_access_arb u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_wr    (data_wr),
        .set_rd    (data_rd || (cmd_addr_ld && cmd_rd_mode)),
        .clr_rd    (cmd_addr_ld && !cmd_rd_mode),
        .grant     (mem_grant),
        .req       (mem_req),
        .we        (mem_we),
        .served_wr (served_wr),
        .served_rd (served_rd)
    );

    vhp_addr_cnt #(.ADDR_W(ADDR_W)) u_addr (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (cmd_addr_ld),
        .ld_val (cmd_addr),
        .inc    (served_wr || served_rd),
        .addr   (mem_addr)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_we     <= 1'b0;
            reg_num    <= '0;
            reg_data   <= 8'h00;
            wbuf_q     <= 8'h00;
            rd_latch_q <= 8'h00;
        end else begin
            reg_we <= cmd_reg_wr;
            if (cmd_reg_wr) begin
                reg_num  <= cmd_reg_num;
                reg_data <= cmd_reg_data;
            end
            if (data_wr)   wbuf_q     <= host_wdata;
            if (served_rd) rd_latch_q <= mem_rdata;
        end
    end

    assign mem_wdata  = wbuf_q;
    assign host_rdata = host_sel ? 8'h00 : rd_latch_q;

    // R2
    reg_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    // R6
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_grant && mem_req && !mem_we) |=> $stable(rd_latch_q));
endmodule

// File: tb/vdp_host_port_bench.sv
module vdp_host_port_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_cs = 1'b0, host_wr = 1'b0, host_sel = 1'b0;
    logic [7:0]  host_wdata = 8'h00;
    logic [7:0]  host_rdata;
    logic        reg_we;
    logic [5:0]  reg_num;
    logic [7:0]  reg_data;
    logic        mem_req, mem_we;
    logic [13:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_grant = 1'b0;
    logic [7:0]  mem_rdata;

    int checks = 0;
    int fails  = 0;
    logic [7:0]  rb;
    logic [13:0] last_wr_addr;
    logic [7:0]  last_wr_data;

    always #4 clk = ~clk;

    function automatic logic [7:0] vpat(input logic [13:0] a);
        return (a[7:0] + 8'h5A) ^ {2'b00, a[13:8]};
    endfunction

    assign mem_rdata = vpat(mem_addr);

    vdp_host_port u_vdp_host_port (
        .clk(clk), .rst_n(rst_n),
        .host_cs(host_cs), .host_wr(host_wr), .host_sel(host_sel),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .reg_we(reg_we), .reg_num(reg_num), .reg_data(reg_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_grant(mem_grant), .mem_rdata(mem_rdata)
    );

    always @(posedge clk)
        if (mem_grant && mem_req && mem_we) begin
            last_wr_addr <= mem_addr;
            last_wr_data <= mem_wdata;
        end

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic sel, input logic wr, input logic [7:0] d,
                       output logic [7:0] r);
        @(negedge clk);
        host_cs = 1'b1; host_sel = sel; host_wr = wr; host_wdata = d;
        #1 r = host_rdata;
        @(negedge clk);
        host_cs = 1'b0;
        #1;
    endtask

    task automatic grant_pulse();
        @(negedge clk); mem_grant = 1'b1;
        @(negedge clk); mem_grant = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        check("R1 mem_req", 16'(mem_req), 16'h0);
        check("R1 reg_we", 16'(reg_we), 16'h0);
        acc(1'b0, 1'b0, 8'h00, rb);
        check("R1 data read", 16'(rb), 16'h00);
    endtask

    task automatic t_reg_write();
        acc(1'b1, 1'b1, 8'hA5, rb);
        check("R2 no strobe after one byte", 16'(reg_we), 16'h0);
        acc(1'b1, 1'b1, 8'h85, rb);
        check("R2 strobe", 16'(reg_we), 16'h1);
        check("R2 reg_num", 16'(reg_num), 16'h05);
        check("R2 reg_data", 16'(reg_data), 16'hA5);
        @(negedge clk); #1;
        check("R2 single cycle", 16'(reg_we), 16'h0);
    endtask

    task automatic t_read_prefetch();
        acc(1'b1, 1'b1, 8'h34, rb);
        acc(1'b1, 1'b1, 8'h12, rb);
        check("R3 req", 16'(mem_req), 16'h1);
        check("R3 we", 16'(mem_we), 16'h0);
        check("R3 addr", 16'(mem_addr), 16'h1234);
        acc(1'b0, 1'b0, 8'h00, rb);
        check("R6 stale read", 16'(rb), 16'h00);
        grant_pulse();
        acc(1'b0, 1'b0, 8'h00, rb);
        check("R7 fetched byte", 16'(rb), 16'(vpat(14'h1234)));
        check("R7 next fetch addr", 16'(mem_addr), 16'h1235);
        check("R7 next fetch req", 16'({mem_req, mem_we}), 16'h2);
    endtask

    task automatic t_write_buffer();
        acc(1'b1, 1'b1, 8'h00, rb);
        acc(1'b1, 1'b1, 8'h40, rb);
        check("R4 prefetch dropped", 16'(mem_req), 16'h0);
        check("R4 addr", 16'(mem_addr), 16'h0000);
        grant_pulse();
        check("R11 idle grant", 16'(mem_addr), 16'h0000);
        acc(1'b0, 1'b1, 8'h77, rb);
        check("R5 req/we", 16'({mem_req, mem_we}), 16'h3);
        check("R5 wdata", 16'(mem_wdata), 16'h77);
        repeat (3) @(negedge clk);
        #1 check("R5 held", 16'({mem_req, mem_we}), 16'h3);
        grant_pulse();
        check("R5 committed", 16'({last_wr_addr, last_wr_data}), 16'({14'h0000, 8'h77}));
        check("R5 req drops", 16'(mem_req), 16'h0);
        acc(1'b0, 1'b1, 8'h88, rb);
        check("R5 increment", 16'(mem_addr), 16'h0001);
        grant_pulse();
    endtask

    task automatic t_priority();
        acc(1'b1, 1'b1, 8'h00, rb);
        acc(1'b1, 1'b1, 8'h01, rb);
        acc(1'b0, 1'b1, 8'h99, rb);
        check("R8 write first", 16'({mem_req, mem_we}), 16'h3);
        grant_pulse();
        check("R8 write addr", 16'(last_wr_addr), 16'h0100);
        check("R8 fetch next", 16'({mem_req, mem_we}), 16'h2);
        check("R8 fetch addr", 16'(mem_addr), 16'h0101);
        grant_pulse();
        acc(1'b0, 1'b0, 8'h00, rb);
        check("R8 fetched", 16'(rb), 16'(vpat(14'h0101)));
    endtask

    task automatic t_flag_reset();
        acc(1'b1, 1'b1, 8'h55, rb);
        acc(1'b0, 1'b0, 8'h00, rb);
        acc(1'b1, 1'b1, 8'h20, rb);
        acc(1'b1, 1'b1, 8'h87, rb);
        check("R9 data access resets", 16'({reg_we, 2'b00, reg_num, reg_data}),
              16'({1'b1, 2'b00, 6'd7, 8'h20}));
        acc(1'b1, 1'b1, 8'h11, rb);
        acc(1'b1, 1'b0, 8'h00, rb);
        check("R9 control read value", 16'(rb), 16'h00);
        acc(1'b1, 1'b1, 8'h33, rb);
        acc(1'b1, 1'b1, 8'h82, rb);
        check("R9 control read resets", 16'({reg_we, 2'b00, reg_num, reg_data}),
              16'({1'b1, 2'b00, 6'd2, 8'h33}));
    endtask

    task automatic t_wrap();
        acc(1'b1, 1'b1, 8'hFF, rb);
        acc(1'b1, 1'b1, 8'h7F, rb);
        acc(1'b0, 1'b1, 8'h3C, rb);
        check("R10 top addr", 16'(mem_addr), 16'h3FFF);
        grant_pulse();
        check("R10 wrapped", 16'(mem_addr), 16'h0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_reg_write();
        t_read_prefetch();
        t_write_buffer();
        t_priority();
        t_flag_reset();
        t_wrap();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule